// File: doc/BRIEF.md
# Windowed CPU-to-PCI Address Translator

This block lets a host CPU with a 26-bit address reach any part of a 32-bit PCI address space. It holds eight rewritable window entries. The CPU address selects one entry. The entry supplies the upper ten PCI address bits. The low 22 bits of the CPU address pass through unchanged as the offset inside a 4 MB window. Software reprograms the entries whenever it wants to reach a different part of PCI space.

Each entry also carries a space flag. This flag decides whether the access becomes a PCI memory cycle or an I/O cycle. Only the read/write direction is taken from the CPU transfer itself. A lookup gives a registered PCI address and a bus command code one cycle later. Those outputs then feed a PCI bus master, which is outside this block.

Top module: `pci_window_xlate`

## Requirements
- R1: After reset, out_valid, out_addr and out_cmd are 0. Every entry holds base 0 with the space flag at 0 (I/O).
- R2: The entry index is lk_addr[24:22]. lk_addr[25] has no effect on the result, so the index aliases.
- R3: out_addr[21:0] equals lk_addr[21:0] of the lookup.
- R4: out_addr[31:22] equals the 10-bit base of the selected entry.
- R5: out_cmd depends on the entry's space flag and on lk_write:
  - flag 1, read gives 4'b0110; flag 1, write gives 4'b0111.
  - flag 0, read gives 4'b0010; flag 0, write gives 4'b0011.
- R6: A table write takes effect from the next cycle. A lookup of the same entry in the same cycle returns the old base and flag.
- R7: out_valid is high exactly in the cycle after a cycle with lk_valid high. Address and command are valid in that same cycle.
- R8: In a cycle after lk_valid was low, out_valid is 0 and out_addr and out_cmd keep their previous values.
- R9: Writing one entry leaves the base and flag of every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Entry to write |
| cfg_base | input | 10 | New base (PCI address bits 31:22) |
| cfg_mem | input | 1 | New space flag: 1 memory, 0 I/O |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 26 | CPU address |
| lk_write | input | 1 | 1 write, 0 read |
| out_valid | output | 1 | Translated result valid |
| out_addr | output | 32 | Translated PCI address |
| out_cmd | output | 4 | PCI bus command |

## Verification
The bench loads distinct bases into all eight entries and alternates the space flags. It then looks up every entry with both directions, with bit 25 at 0 and at 1, and with offsets at zero, at all ones and at a mixed pattern. This separates errors in the index, in the aliasing, in the offset and in the command. A second sweep writes each of the 1024 base values once, which shows any base bit that is stuck or swapped. Directed cases cover four things:
- a write and a lookup of the same entry in the same cycle;
- idle cycles, where the outputs must hold;
- the isolation of one entry from a write to another;
- the reset contents of the table.

// File: rtl/pci_window_xlate.sv
module pci_window_xlate #(
  parameter int CPU_AW = 26,
  parameter int PCI_AW = 32,
  parameter int WIN_W  = 22,
  parameter int N_WIN  = 8,
  localparam int IDX_W  = $clog2(N_WIN),
  localparam int BASE_W = PCI_AW - WIN_W,
  localparam int HI_W   = CPU_AW - WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_mem,
  input  logic              lk_valid,
  input  logic [CPU_AW-1:0] lk_addr,
  input  logic              lk_write,
  output logic              out_valid,
  output logic [PCI_AW-1:0] out_addr,
  output logic [3:0]        out_cmd
);
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  logic [BASE_W-1:0] base_q [N_WIN];
  logic [N_WIN-1:0]  mem_q;

  for (genvar e = 0; e < N_WIN; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[e] <= '0;
        mem_q[e]  <= 1'b0;
      end else if (cfg_we && cfg_idx == IDX_W'(e)) begin
        base_q[e] <= cfg_base;
        mem_q[e]  <= cfg_mem;
      end
    end
  end

  logic [HI_W-1:0]  hi;
  logic [IDX_W-1:0] sel;
  logic [3:0]       cmd_d;

  assign hi  = lk_addr[CPU_AW-1:WIN_W];
  assign sel = IDX_W'(hi % HI_W'(N_WIN));

  always_comb begin
    case ({mem_q[sel], lk_write})
      2'b00:   cmd_d = CMD_IO_RD;
      2'b01:   cmd_d = CMD_IO_WR;
      2'b10:   cmd_d = CMD_MEM_RD;
      default: cmd_d = CMD_MEM_WR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_cmd   <= '0;
    end else begin
      out_valid <= lk_valid;
      if (lk_valid) begin
        out_addr <= {base_q[sel], lk_addr[WIN_W-1:0]};
        out_cmd  <= cmd_d;
      end
    end
  end
endmodule

// File: rtl/pci_window_xlate_chk.sv
module pci_window_xlate_chk #(
  parameter int CPU_AW = 26,
  parameter int PCI_AW = 32,
  parameter int WIN_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [CPU_AW-1:0] lk_addr,
  input logic              lk_write,
  input logic              out_valid,
  input logic [PCI_AW-1:0] out_addr,
  input logic [3:0]        out_cmd
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(lk_valid)); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[WIN_W-1:0] == $past(lk_addr[WIN_W-1:0])); // R3
  AST_CMD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cmd[0] == $past(lk_write)); // R5
  AST_CMD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cmd[3] == 1'b0 && out_cmd[1] == 1'b1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_addr) && $stable(out_cmd))); // R8
endmodule

bind pci_window_xlate pci_window_xlate_chk #(
  .CPU_AW(CPU_AW), .PCI_AW(PCI_AW), .WIN_W(WIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_write(lk_write), .out_valid(out_valid), .out_addr(out_addr),
  .out_cmd(out_cmd)
);

// File: tb/tb_pci_window_xlate.sv
module tb_pci_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [9:0]  cfg_base = '0;
  logic        cfg_mem = 1'b0;
  logic        lk_valid = 1'b0;
  logic [25:0] lk_addr = '0;
  logic        lk_write = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [3:0]  out_cmd;

  int tests = 0;
  int fails = 0;
  logic [9:0] mb [8];
  logic       mm [8];

  always #10 clk = ~clk;

  pci_window_xlate dut (.*);

  function automatic logic [3:0] ecmd(input logic mem, input logic wr);
    return mem ? (wr ? 4'b0111 : 4'b0110) : (wr ? 4'b0011 : 4'b0010);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [9:0] b, input logic m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_mem = m;
    @(negedge clk);
    cfg_we = 1'b0;
    mb[idx] = b; mm[idx] = m;
  endtask

  task automatic look(input string req, input logic [25:0] a, input logic w);
    int i;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_write = w;
    @(negedge clk);
    lk_valid = 1'b0;
    i = int'(a[24:22]);
    chk(req, {3'b0, out_valid, out_addr}, {3'b0, 1'b1, mb[i], a[21:0]});
    chk(req, {32'b0, out_cmd}, {32'b0, ecmd(mm[i], w)});
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic [3:0]  pc;
    for (int e = 0; e < 8; e++) begin mb[e] = '0; mm[e] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1", {3'b0, out_valid, out_addr}, 36'h0);
    chk("R1", {32'b0, out_cmd}, 36'h0);
    rst_n = 1'b1;
    look("R1", {1'b0, 3'd5, 22'h0ABCDE}, 1'b1);

    for (int e = 0; e < 8; e++) wr(e, 10'((e * 129 + 37) & 1023), e[0]);
    for (int e = 0; e < 8; e++)
      for (int h = 0; h < 2; h++)
        for (int w = 0; w < 2; w++) begin
          look("R2 R3 R4 R5", {h[0], 3'(e), 22'h000000}, w[0]);
          look("R2 R3 R4 R5", {h[0], 3'(e), 22'h3FFFFF}, w[0]);
          look("R2 R3 R4 R5", {h[0], 3'(e), 22'h155555}, w[0]);
        end

    for (int b = 0; b < 1024; b++) begin
      wr(b % 8, 10'(b), b[3]);
      look("R4 sweep", {b[4], 3'(b % 8), 22'((b * 4099) & 22'h3FFFFF)}, b[5]);
    end

    wr(3, 10'h155, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_base = 10'h2AA; cfg_mem = 1'b1;
    lk_valid = 1'b1; lk_addr = {1'b0, 3'd3, 22'h001234}; lk_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    chk("R6 old", {3'b0, out_valid, out_addr}, {4'b0001, 10'h155, 22'h001234});
    chk("R6 old", {32'b0, out_cmd}, 36'h2);
    mb[3] = 10'h2AA; mm[3] = 1'b1;
    look("R6 new", {1'b0, 3'd3, 22'h001234}, 1'b0);

    pa = out_addr; pc = out_cmd;
    repeat (2) begin
      @(negedge clk);
      chk("R8", {3'b0, out_valid, out_addr}, {3'b0, 1'b0, pa});
      chk("R8", {32'b0, out_cmd}, {32'b0, pc});
    end

    wr(6, 10'h3C3, 1'b1);
    for (int e = 0; e < 8; e++) look("R9", {1'b1, 3'(e), 22'h2A0F0F}, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule